// File: doc/BRIEF.md
# Destination Address Hash Filter

This block decides whether a received Ethernet frame should be kept, judging only by its 48-bit destination address. The address arrives one byte per cycle, first byte marked with a start strobe and every byte qualified by a valid strobe. While the bytes stream in, the block folds them into a CRC-32, compares them with the programmed station address and tracks whether every bit is one. When the sixth byte is taken, it combines these results with a 64-bit multicast hash table and four mode bits to produce a one-cycle decision.

The hash table is written by software as two 32-bit words. A byte-order input selects between two layouts of those words, which lets one design serve both register layouts in use. Address matching takes precedence as follows: an all-ones address is broadcast; any other address with the group bit set is multicast and is looked up in the hash table; an address with the group bit clear is compared with the station address. A promiscuous mode bit accepts every completed address, whatever its kind.

Top module: `addr_hash_filter`

## Requirements
- R1: A frame begins on a cycle with both byte_start and byte_valid high; that byte is byte 0, and the next five cycles with byte_valid high (idle cycles may come between them) deliver bytes 1 to 5. Valid bytes outside a frame are ignored, and a new start in mid-frame restarts at byte 0.
- R2: With mode bit 0 set every completed address is accepted; with mode equal to 0 every address is rejected.
- R3: The hash CRC starts at all ones and takes each byte least-significant bit first; per bit, feedback = CRC bit 31 XOR data bit, the CRC shifts left by one, and on feedback 1 it is XORed with 0x04C11DB7. The hash index is CRC bits 31:26 after the sixth byte.
- R4: tbl_sel 0 writes the low register and tbl_sel 1 the high register, effective from the next cycle. With swap_order 0 the table is {high, low} (table bit i = bit i of that 64-bit value). With swap_order 1 the low register holds table bits 63:32 byte-reversed and the high register holds table bits 31:0 byte-reversed.
- R5: An all-ones address reports match code 3 (broadcast), ahead of any hash lookup, and is accepted when mode bit 3 is set.
- R6: An address whose byte 0 bit 0 is 1, not all ones, with its indexed table bit set reports match code 2 (multicast) and is accepted when mode bit 2 is set; a group address whose table bit is 0 reports code 0.
- R7: Station byte k is station_lo[8k+7:8k] for k = 0..3 and station_hi[8(k-4)+7:8(k-4)] for k = 4, 5. An address with byte 0 bit 0 clear that equals the station reports match code 1 (physical) and is accepted when mode bit 1 is set; any other such address reports code 0.
- R8: dec_valid, dec_accept and dec_match are registered and hold the decision for exactly the cycle after the edge that samples byte 5; at all other times they are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_start | input | 1 | Marks byte 0 of an address |
| byte_valid | input | 1 | Qualifies byte_data |
| byte_data | input | 8 | Address byte |
| station_lo | input | 32 | Station address bytes 0 to 3, byte 0 in bits 7:0 |
| station_hi | input | 16 | Station address bytes 4 and 5, byte 4 in bits 7:0 |
| mode | input | 4 | bit0 promiscuous, bit1 physical, bit2 multicast, bit3 broadcast |
| swap_order | input | 1 | Selects the byte-reversed table layout |
| tbl_we | input | 1 | Hash table write enable |
| tbl_sel | input | 1 | Table word select: 0 low, 1 high |
| tbl_wdata | input | 32 | Table write data |
| dec_valid | output | 1 | Decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_match | output | 2 | 0 none, 1 physical, 2 multicast, 3 broadcast |

## Verification
Every decision is due one clock after the edge that samples the sixth valid byte, so the bench presents bytes on falling edges, waits for the next rising edge and reads the three outputs a moment later; it then checks that dec_valid has dropped one cycle further on. A table write is due from the following cycle, so table writes finish on a falling edge before the frame that depends on them starts. Idle gaps between bytes and stray valid bytes before a start move the decision cycle only by the counted bytes, which the bench follows by construction of its stimulus.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
  typedef enum logic [1:0] {
    MT_NONE  = 2'd0,
    MT_PHYS  = 2'd1,
    MT_MCAST = 2'd2,
    MT_BCAST = 2'd3
  } match_t;

  localparam int MODE_W       = 4;
  localparam int MODE_PROMISC = 0;
  localparam int MODE_PHYS    = 1;
  localparam int MODE_MCAST   = 2;
  localparam int MODE_BCAST   = 3;
endpackage

// File: rtl/hash_crc_unit.sv
module hash_crc_unit #(
  parameter int              CRC_W  = 32,
  parameter logic [31:0]     POLY   = 32'h04C11DB7,
  parameter int              DATA_W = 8,
  parameter int              OUT_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init,
  input  logic              en,
  input  logic [DATA_W-1:0] data,
  output logic [OUT_W-1:0]  crc_top
);
  logic [CRC_W-1:0] crc_q;
  logic [CRC_W-1:0] crc_nx;

  // bit-serial recurrence unrolled over one byte, LSB first
  always_comb begin
    crc_nx = init ? '1 : crc_q;
    for (int b = 0; b < DATA_W; b++) begin
      if (crc_nx[CRC_W-1] ^ data[b])
        crc_nx = (crc_nx << 1) ^ POLY[CRC_W-1:0];
      else
        crc_nx = crc_nx << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     crc_q <= '1;
    else if (en) crc_q <= crc_nx;
  end

  assign crc_top = crc_nx[CRC_W-1 -: OUT_W];
endmodule

// File: rtl/hash_table_regs.sv
module hash_table_regs #(
  parameter int WORD_W  = 32,
  parameter int TABLE_W = 64,
  localparam int NWORDS = TABLE_W / WORD_W,
  localparam int BYTES  = WORD_W / 8,
  localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [SEL_W-1:0]   sel,
  input  logic [WORD_W-1:0]  wdata,
  input  logic               swap,
  output logic [TABLE_W-1:0] table_o
);
  logic [WORD_W-1:0]  words_q [NWORDS];
  logic [TABLE_W-1:0] plain_flat;
  logic [TABLE_W-1:0] rev_flat;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NWORDS; k++) words_q[k] <= '0;
    end else if (we && (int'(sel) < NWORDS)) begin
      words_q[sel] <= wdata;
    end
  end

  // swapped layout: register k carries logical word NWORDS-1-k, bytes reversed
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign plain_flat[WORD_W*k +: WORD_W] = words_q[k];
    for (genvar b = 0; b < BYTES; b++) begin : g_byte
      assign rev_flat[WORD_W*k + 8*b +: 8] = words_q[NWORDS-1-k][8*(BYTES-1-b) +: 8];
    end
  end

  assign table_o = swap ? rev_flat : plain_flat;
endmodule

// File: rtl/addr_match_track.sv
module addr_match_track #(
  parameter int ADDR_BYTES = 6,
  localparam int ST_W  = 8 * ADDR_BYTES,
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             first,
  input  logic             take,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  input  logic [ST_W-1:0]  station,
  output logic             phys_n,
  output logic             ones_n,
  output logic             group_n
);
  logic [ADDR_BYTES-1:0] eq_vec;
  logic phys_q, ones_q, group_q;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_cmp
    assign eq_vec[k] = (data == station[8*k +: 8]);
  end

  assign phys_n  = (first | phys_q) & eq_vec[idx];
  assign ones_n  = (first | ones_q) & (&data);
  assign group_n = first ? data[0] : group_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_q  <= 1'b0;
      ones_q  <= 1'b0;
      group_q <= 1'b0;
    end else if (take) begin
      phys_q  <= phys_n;
      ones_q  <= ones_n;
      group_q <= group_n;
    end
  end
endmodule

// File: rtl/addr_hash_filter.sv
module addr_hash_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter int          CRC_W      = 32,
  parameter logic [31:0] POLY       = 32'h04C11DB7,
  parameter int          HASH_BITS  = 6,
  parameter int          WORD_W     = 32,
  localparam int TABLE_W = 1 << HASH_BITS,
  localparam int NWORDS  = TABLE_W / WORD_W,
  localparam int SEL_W   = (NWORDS > 1) ? $clog2(NWORDS) : 1,
  localparam int ST_W    = 8 * ADDR_BYTES,
  localparam int IDX_W   = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      byte_start,
  input  logic                      byte_valid,
  input  logic [7:0]                byte_data,
  input  logic [WORD_W-1:0]         station_lo,
  input  logic [ST_W-WORD_W-1:0]    station_hi,
  input  logic [3:0]                mode,
  input  logic                      swap_order,
  input  logic                      tbl_we,
  input  logic [SEL_W-1:0]          tbl_sel,
  input  logic [WORD_W-1:0]         tbl_wdata,
  output logic                      dec_valid,
  output logic                      dec_accept,
  output logic [1:0]                dec_match
);
  import addr_filt_pkg::*;

  logic             busy_q;
  logic [IDX_W-1:0] cnt_q;
  logic             first, take, last;
  logic [IDX_W-1:0] idx;
  logic [HASH_BITS-1:0] hidx;
  logic [TABLE_W-1:0]   table_w;
  logic phys_n, ones_n, group_n;
  match_t kind;
  logic   acc;

  assign first = byte_valid & byte_start;
  assign take  = byte_valid & (byte_start | busy_q);
  assign idx   = first ? '0 : cnt_q;
  assign last  = take && (idx == IDX_W'(ADDR_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (take) begin
      if (last) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        busy_q <= 1'b1;
        cnt_q  <= idx + 1'b1;
      end
    end
  end

  hash_crc_unit #(
    .CRC_W(CRC_W), .POLY(POLY), .DATA_W(8), .OUT_W(HASH_BITS)
  ) u_crc (
    .clk(clk), .rst(rst), .init(first), .en(take),
    .data(byte_data), .crc_top(hidx)
  );

  hash_table_regs #(
    .WORD_W(WORD_W), .TABLE_W(TABLE_W)
  ) u_tbl (
    .clk(clk), .rst(rst), .we(tbl_we), .sel(tbl_sel),
    .wdata(tbl_wdata), .swap(swap_order), .table_o(table_w)
  );

  addr_match_track #(
    .ADDR_BYTES(ADDR_BYTES)
  ) u_trk (
    .clk(clk), .rst(rst), .first(first), .take(take), .idx(idx),
    .data(byte_data), .station({station_hi, station_lo}),
    .phys_n(phys_n), .ones_n(ones_n), .group_n(group_n)
  );

  // broadcast wins over the hash, group addresses never match the station
  always_comb begin
    if (ones_n)                     kind = MT_BCAST;
    else if (group_n)               kind = table_w[hidx] ? MT_MCAST : MT_NONE;
    else if (phys_n)                kind = MT_PHYS;
    else                            kind = MT_NONE;
    acc = mode[MODE_PROMISC]
        | (mode[MODE_BCAST] & (kind == MT_BCAST))
        | (mode[MODE_MCAST] & (kind == MT_MCAST))
        | (mode[MODE_PHYS]  & (kind == MT_PHYS));
  end

  always_ff @(posedge clk) begin
    if (rst || !last) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_match  <= MT_NONE;
    end else begin
      dec_valid  <= 1'b1;
      dec_accept <= acc;
      dec_match  <= kind;
    end
  end
endmodule

// File: rtl/addr_filter_chk.sv
module addr_filter_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_valid,
  input logic [3:0] mode,
  input logic       dec_valid,
  input logic       dec_accept,
  input logic [1:0] dec_match
);
  // R8: the decision strobe lasts one cycle
  p_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    dec_valid |=> !dec_valid);

  // R8: outputs are quiet outside the decision cycle
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> (!dec_accept && dec_match == 2'd0));

  // R1: a decision always follows a sampled byte
  p_cause_r1: assert property (@(posedge clk) disable iff (rst)
    dec_valid |-> $past(byte_valid));

  // R2: promiscuous accepts everything
  p_promisc_r2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(mode[0])) |-> dec_accept);

  // R2: all modes off rejects everything
  p_reject_r2: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && $past(mode) == 4'd0) |-> !dec_accept);

  // R5: broadcast with its enable is accepted
  p_bcast_r5: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_match == 2'd3 && $past(mode[3])) |-> dec_accept);

  // R6 R7: without promiscuous, an accept needs a match
  p_cause_r6: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_accept && !$past(mode[0])) |-> dec_match != 2'd0);
endmodule

bind addr_hash_filter addr_filter_chk u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .mode(mode),
  .dec_valid(dec_valid), .dec_accept(dec_accept), .dec_match(dec_match)
);

// File: tb/sim_addr_hash_filter.sv
`timescale 1ns/1ps
module sim_addr_hash_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_start = 1'b0, byte_valid = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic [31:0] station_lo;
  logic [15:0] station_hi;
  logic [3:0]  mode = 4'd0;
  logic        swap_order = 1'b0;
  logic        tbl_we = 1'b0;
  logic        tbl_sel = 1'b0;
  logic [31:0] tbl_wdata = 32'h0;
  logic        dec_valid, dec_accept;
  logic [1:0]  dec_match;

  int n_checks = 0;
  int n_fail   = 0;
  logic [47:0] station = 48'hA1B2C3D4E5F6;
  logic [63:0] tbl_model = 64'h0;
  logic [63:0] seed = 64'h1234_5678_9ABC_DEF1;

  assign station_lo = station[31:0];
  assign station_hi = station[47:32];

  always #5 clk = ~clk;

  addr_hash_filter u0 (
    .clk(clk), .rst(rst), .byte_start(byte_start), .byte_valid(byte_valid),
    .byte_data(byte_data), .station_lo(station_lo), .station_hi(station_hi),
    .mode(mode), .swap_order(swap_order), .tbl_we(tbl_we), .tbl_sel(tbl_sel),
    .tbl_wdata(tbl_wdata), .dec_valid(dec_valid), .dec_accept(dec_accept),
    .dec_match(dec_match)
  );

  function automatic logic [5:0] crc_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 6; i++)
      for (int j = 0; j < 8; j++) begin
        logic fb = c[31] ^ a[8*i + j];
        c = c << 1;
        if (fb) c = c ^ 32'h04C11DB7;
      end
    return c[31:26];
  endfunction

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [2:0] expect_of(input logic [47:0] a, input logic [3:0] m);
    logic [1:0] mt;
    logic acc;
    if (a == '1)                    mt = 2'd3;
    else if (a[0])                  mt = tbl_model[crc_index(a)] ? 2'd2 : 2'd0;
    else if (a == station)          mt = 2'd1;
    else                            mt = 2'd0;
    acc = m[0] | (m[3] && mt == 2'd3) | (m[2] && mt == 2'd2) | (m[1] && mt == 2'd1);
    return {acc, mt};
  endfunction

  function automatic logic [47:0] next_addr();
    seed = seed * 64'd6364136223846793005 + 64'd1442695040888963407;
    return seed[63:16];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_table(input logic [63:0] t, input logic sw);
    @(negedge clk);
    swap_order = sw;
    tbl_we = 1'b1; tbl_sel = 1'b0;
    tbl_wdata = sw ? bswap(t[63:32]) : t[31:0];
    @(negedge clk);
    tbl_sel = 1'b1;
    tbl_wdata = sw ? bswap(t[31:0]) : t[63:32];
    @(negedge clk);
    tbl_we = 1'b0;
    tbl_model = t;
  endtask

  task automatic send_frame(input logic [47:0] a, input logic gap, input string tag);
    logic [2:0] e;
    e = expect_of(a, mode);
    @(negedge clk);
    byte_start = 1'b1; byte_valid = 1'b1; byte_data = a[7:0];
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      byte_start = 1'b0;
      if (gap) begin
        byte_valid = 1'b0; byte_data = 8'h5A;
        @(negedge clk);
      end
      byte_valid = 1'b1; byte_data = a[8*i +: 8];
    end
    @(posedge clk); #1;
    check(tag, {29'd0, dec_valid, dec_accept, dec_match}, {29'd0, 1'b1, e});
    @(negedge clk);
    byte_valid = 1'b0;
    @(posedge clk); #1;
    check("R8 strobe drop", {31'd0, dec_valid}, 32'd0);
  endtask

  function automatic string tag_of(input logic [47:0] a, input logic [3:0] m);
    logic [2:0] e = expect_of(a, m);
    if (m[0])           return "R2 promiscuous";
    if (m == 4'd0)      return "R2 all off";
    case (e[1:0])
      2'd3:    return "R5 broadcast";
      2'd2:    return "R6 multicast hit";
      2'd1:    return "R7 physical";
      default: return a[0] ? "R6 multicast miss" : "R7 unicast miss";
    endcase
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    logic [47:0] alist [6];
    int seen;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R8 reset state", {29'd0, dec_valid, dec_accept, dec_match}, 32'd0);

    write_table(64'hF0E1_D2C3_B4A5_9687, 1'b0);
    alist[0] = '1;
    alist[1] = station;
    alist[2] = station ^ 48'h0100_0000_0000;
    alist[3] = 48'h0000_5E00_0001;
    alist[4] = 48'h0033_0000_0133;
    alist[5] = 48'h1000_0000_0001;
    // R3 also covered: a hit or miss depends on the CRC index
    for (int m = 0; m < 16; m++) begin
      mode = 4'(m);
      for (int k = 0; k < 6; k++) send_frame(alist[k], m[0], tag_of(alist[k], mode));
    end

    // R4: table layouts with shifting contents, R3 index sweep
    mode = 4'b0100;
    for (int t = 0; t < 64; t++) begin
      logic [63:0] pat = {64'h9E37_79B9_7F4A_7C15} << t | {64'h9E37_79B9_7F4A_7C15} >> (64 - t);
      write_table(pat, t[0]);
      for (int r = 0; r < 3; r++) begin
        logic [47:0] a = next_addr() | 48'h1;
        if (a == '1) a[1] = 1'b0;
        send_frame(a, 1'b0, t[0] ? "R4 swapped R3 index" : "R4 plain R3 index");
      end
    end

    // R1: valid bytes with no start are ignored
    mode = 4'b1111;
    seen = 0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      byte_start = 1'b0; byte_valid = 1'b1; byte_data = 8'(i);
      @(posedge clk); #1;
      if (dec_valid) seen++;
    end
    @(negedge clk) byte_valid = 1'b0;
    @(posedge clk); #1;
    if (dec_valid) seen++;
    check("R1 stray bytes ignored", seen, 0);

    // R1: restart mid-frame, decision follows the second start only
    mode = 4'b0010;
    seen = 0;
    @(negedge clk);
    byte_start = 1'b1; byte_valid = 1'b1; byte_data = 8'hFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      byte_start = 1'b0; byte_data = 8'hFF;
      @(posedge clk); #1;
      if (dec_valid) seen++;
    end
    send_frame(station, 1'b0, "R1 restart physical R7");
    check("R1 restart no early decision", seen, 0);

    // R7: station byte placement, each byte differing once
    for (int k = 0; k < 6; k++)
      send_frame(station ^ (48'h80 << (8*k)), 1'b1, "R7 byte position");

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule